// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive side of an Ethernet MAC and decides whether an incoming frame should be kept, using only the 48-bit destination address at the head of the frame. Software programs a station address through three 16-bit words and enables two classes of acceptance: exact match with the station address, and the all-ones broadcast address.

The six destination bytes arrive one per clock on `rx_byte`. `rx_valid` qualifies each byte, and `rx_sof` marks the first one. Cycles with `rx_valid` low may fall between bytes. As each byte arrives, the block keeps two running match flags. One clock after the sixth byte it raises `dec_valid` for a single cycle, together with an accept bit and a code for the class that matched.

The address and enables in force for a frame are captured when its first byte arrives. Reprogramming during a frame therefore never produces a decision from a mix of old and new settings.

Top module: `rx_addr_filter`

## Requirements
- R1: The first received byte is address byte 0. Write select 2 holds bytes 0 (bits 7:0) and 1 (bits 15:8). Select 1 holds bytes 2 (7:0) and 3 (15:8). Select 0 holds bytes 4 (7:0) and 5 (15:8).
- R2: Write select 3 is the control word. When its bit 5 is set, a destination equal to the station address is accepted with `dec_kind` 2'b01.
- R3: When control bit 1 is set, the destination FF:FF:FF:FF:FF:FF is accepted with `dec_kind` 2'b10.
- R4: When no enabled class matches, the frame is rejected with `dec_accept` 0 and `dec_kind` 2'b00. A class that matches while its enable bit is clear causes no acceptance. Outside the decision pulse, `dec_accept` and `dec_kind` are 0.
- R5: `dec_valid` is high for exactly the one cycle after the clock edge that captures the sixth byte, and at no other time.
- R6: When both classes match and both are enabled, the result is `dec_kind` 2'b01 (perfect match has priority).
- R7: A byte with `rx_sof` that arrives before six bytes of the current frame have been seen restarts the comparison with that byte as byte 0. The abandoned frame produces no decision.
- R8: A write to the station-address words or the control word while a frame is in progress does not affect that frame. It applies from the next `rx_sof`.
- R9: Bytes with `rx_valid` high but `rx_sof` low are ignored when no frame is in progress. This includes bytes that follow the sixth byte.
- R10: After reset, `dec_valid`, `dec_accept` and `dec_kind` are 0, and all station-address words and the control word are 0.
- R11: Cycles with `rx_valid` low inside a frame do not count as bytes and do not disturb the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration words |
| cfg_sel | input | 2 | Word select: 0..2 station address, 3 control |
| cfg_wdata | input | 16 | Write data |
| rx_valid | input | 1 | Qualifies `rx_byte` |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_byte | input | 8 | Received byte |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted (valid with `dec_valid`) |
| dec_kind | output | 2 | 00 reject, 01 perfect, 10 broadcast |

## Verification
A configuration write takes effect at the clock edge that captures it. The snapshot of that configuration is taken at the edge that captures the first byte. The decision flags are registered at the edge that captures the sixth byte, so they are visible in the half cycle that follows and are gone one cycle later. The bench drives each input on a falling edge and reads the outputs on the next falling edge. It checks that `dec_valid` is low after each of the first five bytes, that the full decision is present immediately after the sixth, and that `dec_valid` is low again one cycle later. Aborted frames, trailing bytes and mid-frame writes are judged against these same cycle positions.

// File: rtl/daf_pkg.sv
`timescale 1ns/1ps
package daf_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_BYTES = 6;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int N_WORDS = N_BYTES / 2;
    localparam int SEL_W   = 2;
    localparam int BC_BIT  = 1;
    localparam int PF_BIT  = 5;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'b00,
        KIND_PERFECT = 2'b01,
        KIND_BCAST   = 2'b10
    } kind_e;
endpackage

// File: rtl/daf_cfg_regs.sv
`timescale 1ns/1ps
module daf_cfg_regs #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 3,
    parameter int SEL_W   = 2,
    parameter int BC_BIT  = 1,
    parameter int PF_BIT  = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [WORD_W-1:0]           cfg_wdata,
    output logic [N_WORDS*WORD_W-1:0]   stn_addr,
    output logic                        bc_en,
    output logic                        pf_en
);
    localparam int CTRL_SEL = N_WORDS;

    typedef struct packed {
        logic [N_WORDS-1:0][WORD_W-1:0] words;
        logic                           bc_en;
        logic                           pf_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (int'(cfg_sel) == CTRL_SEL) begin
                cfg_d.bc_en = cfg_wdata[BC_BIT];
                cfg_d.pf_en = cfg_wdata[PF_BIT];
            end else if (int'(cfg_sel) < N_WORDS) begin
                cfg_d.words[cfg_sel] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // Highest select holds the earliest pair of address bytes.
    for (genvar j = 0; j < N_WORDS; j++) begin : g_map
        assign stn_addr[j*WORD_W +: WORD_W] = cfg_q.words[N_WORDS-1-j];
    end

    assign bc_en = cfg_q.bc_en;
    assign pf_en = cfg_q.pf_en;
endmodule

// File: rtl/daf_byte_sel.sv
`timescale 1ns/1ps
module daf_byte_sel #(
    parameter int N_BYTES = 6,
    parameter int BYTE_W  = 8,
    parameter int IDX_W   = 3
) (
    input  logic [N_BYTES*BYTE_W-1:0] addr,
    input  logic [IDX_W-1:0]          idx,
    output logic [BYTE_W-1:0]         byte_out
);
    logic [BYTE_W-1:0] lanes [N_BYTES];

    for (genvar k = 0; k < N_BYTES; k++) begin : g_lane
        assign lanes[k] = addr[k*BYTE_W +: BYTE_W];
    end

    always_comb begin
        byte_out = '0;
        for (int k = 0; k < N_BYTES; k++) begin
            if (int'(idx) == k) byte_out = lanes[k];
        end
    end
endmodule

// File: rtl/daf_frame_ctrl.sv
`timescale 1ns/1ps
module daf_frame_ctrl
    import daf_pkg::*;
#(
    parameter int N_BYTES = 6,
    parameter int BYTE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic                        rx_sof,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic [N_BYTES*BYTE_W-1:0]   live_addr,
    input  logic                        live_bc_en,
    input  logic                        live_pf_en,
    output logic                        dec_valid,
    output logic                        dec_accept,
    output kind_e                       dec_kind
);
    localparam int AW    = N_BYTES * BYTE_W;
    localparam int CNT_W = $clog2(N_BYTES + 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    snap_addr;
        logic             snap_bc_en;
        logic             snap_pf_en;
        logic             pf_hit;
        logic             bc_hit;
        logic             dv;
        logic             acc;
        kind_e            kind;
    } st_t;

    st_t st_d, st_q;

    logic              start;
    logic [AW-1:0]     ref_addr;
    logic [CNT_W-1:0]  ref_idx;
    logic [BYTE_W-1:0] ref_byte;
    logic              byte_pf, byte_bc, pf_all, bc_all;

    assign start    = rx_valid && rx_sof;
    assign ref_addr = start ? live_addr : st_q.snap_addr;
    assign ref_idx  = start ? '0 : st_q.cnt;

    daf_byte_sel #(
        .N_BYTES (N_BYTES),
        .BYTE_W  (BYTE_W),
        .IDX_W   (CNT_W)
    ) u_sel (
        .addr     (ref_addr),
        .idx      (ref_idx),
        .byte_out (ref_byte)
    );

    assign byte_pf = (rx_byte == ref_byte);
    assign byte_bc = (rx_byte == {BYTE_W{1'b1}});

    always_comb begin
        st_d      = st_q;
        st_d.dv   = 1'b0;
        st_d.acc  = 1'b0;
        st_d.kind = KIND_NONE;
        pf_all    = st_q.pf_hit & byte_pf;
        bc_all    = st_q.bc_hit & byte_bc;
        if (start) begin
            st_d.active     = 1'b1;
            st_d.cnt        = CNT_W'(1);
            st_d.snap_addr  = live_addr;
            st_d.snap_bc_en = live_bc_en;
            st_d.snap_pf_en = live_pf_en;
            st_d.pf_hit     = byte_pf;
            st_d.bc_hit     = byte_bc;
        end else if (rx_valid && st_q.active) begin
            st_d.cnt    = st_q.cnt + 1'b1;
            st_d.pf_hit = pf_all;
            st_d.bc_hit = bc_all;
            if (st_q.cnt == CNT_W'(N_BYTES - 1)) begin
                st_d.active = 1'b0;
                st_d.dv     = 1'b1;
                if (st_q.snap_pf_en && pf_all) begin
                    st_d.acc  = 1'b1;
                    st_d.kind = KIND_PERFECT;
                end else if (st_q.snap_bc_en && bc_all) begin
                    st_d.acc  = 1'b1;
                    st_d.kind = KIND_BCAST;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_valid  = st_q.dv;
    assign dec_accept = st_q.acc;
    assign dec_kind   = st_q.kind;
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
    import daf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [15:0] cfg_wdata,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_byte,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic [1:0]  dec_kind
);
    logic [N_BYTES*BYTE_W-1:0] stn_addr;
    logic                      bc_en, pf_en;
    kind_e                     kind;

    daf_cfg_regs #(
        .WORD_W  (WORD_W),
        .N_WORDS (N_WORDS),
        .SEL_W   (SEL_W),
        .BC_BIT  (BC_BIT),
        .PF_BIT  (PF_BIT)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .stn_addr  (stn_addr),
        .bc_en     (bc_en),
        .pf_en     (pf_en)
    );

    daf_frame_ctrl #(
        .N_BYTES (N_BYTES),
        .BYTE_W  (BYTE_W)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_sof     (rx_sof),
        .rx_byte    (rx_byte),
        .live_addr  (stn_addr),
        .live_bc_en (bc_en),
        .live_pf_en (pf_en),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept),
        .dec_kind   (kind)
    );

    assign dec_kind = kind;
endmodule

// File: rtl/rx_addr_filter_chk.sv
`timescale 1ns/1ps
module rx_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       dec_valid,
    input logic       dec_accept,
    input logic [1:0] dec_kind
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    a_r5_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));

    a_r4_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_kind == 2'b00));

    a_r4_accept_has_kind: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_kind != 2'b00)));

    a_r6_kind_legal: assert property (@(posedge clk) disable iff (!rst_n)
        dec_kind != 2'b11);
endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .dec_kind   (dec_kind)
);

// File: tb/rx_addr_filter_test.sv
`timescale 1ns/1ps
module rx_addr_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        dec_valid, dec_accept;
    logic [1:0]  dec_kind;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    rx_addr_filter uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_kind(dec_kind)
    );

    // Station bytes 0..5 = 02 1A 3C 4D 5E 6F (byte 0 in bits 7:0)
    localparam logic [47:0] STN   = 48'h6F5E_4D3C_1A02;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [47:0] dst;
        logic        acc;
        logic [1:0]  kind;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'h20, STN,               1'b1, 2'b01},
        '{8'h22, BCAST,             1'b1, 2'b10},
        '{8'h20, BCAST,             1'b0, 2'b00},
        '{8'h02, STN,               1'b0, 2'b00},
        '{8'h22, 48'h6E5E_4D3C_1A02, 1'b0, 2'b00},
        '{8'h22, 48'h6F5E_4D3C_1A03, 1'b0, 2'b00},
        '{8'h00, BCAST,             1'b0, 2'b00},
        '{8'h22, 48'h7FFF_FFFF_FFFF, 1'b0, 2'b00}
    };
    localparam string VTAG [8] = '{"R2", "R3", "R4", "R4", "R4", "R4", "R4", "R3"};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic s, input logic [7:0] b);
        rx_valid = v; rx_sof = s; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_byte = '0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog_stn(input logic [47:0] a);
        wr(2'd2, a[15:0]);
        wr(2'd1, a[31:16]);
        wr(2'd0, a[47:32]);
    endtask

    task automatic send(input logic [47:0] dst, input logic gap, input string tag);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, k == 0, dst[8*k +: 8]);
            if (k < 5) begin
                check({tag, " R5 no early decision"}, 8'(dec_valid), 8'h0);
                if (gap) begin
                    cyc(1'b0, 1'b0, 8'hFF);
                    check({tag, " R11 gap"}, 8'(dec_valid), 8'h0);
                end
            end
        end
    endtask

    task automatic expect_dec(input string tag, input logic acc, input logic [1:0] kind);
        check({tag, " R5 valid"}, 8'(dec_valid), 8'h1);
        check({tag, " accept"}, 8'(dec_accept), 8'(acc));
        check({tag, " kind"}, 8'(dec_kind), 8'(kind));
        cyc(1'b0, 1'b0, 8'h00);
        check({tag, " R5 pulse ends"}, 8'(dec_valid), 8'h0);
        check({tag, " R4 accept low after"}, 8'(dec_accept), 8'h0);
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: outputs idle after reset
        check("R10 dec_valid", 8'(dec_valid), 8'h0);
        check("R10 dec_accept", 8'(dec_accept), 8'h0);
        check("R10 dec_kind", 8'(dec_kind), 8'h0);
        // R10: station words reset to zero -> all-zero destination matches
        wr(2'd3, 16'h0020);
        send(48'h0, 1'b0, "R10");
        expect_dec("R10 zero station", 1'b1, 2'b01);

        prog_stn(STN);
        for (int i = 0; i < 8; i++) begin
            wr(2'd3, {8'h00, VECS[i].ctrl});
            send(VECS[i].dst, i[0], VTAG[i]);
            expect_dec(VTAG[i], VECS[i].acc, VECS[i].kind);
        end

        // R1: swapping the two bytes within a word must not match
        wr(2'd3, 16'h0020);
        send(48'h6F5E_4D3C_021A, 1'b0, "R1");
        expect_dec("R1 swapped", 1'b0, 2'b00);

        // R6: both classes match -> perfect wins
        prog_stn(BCAST);
        wr(2'd3, 16'h0022);
        send(BCAST, 1'b0, "R6");
        expect_dec("R6 priority", 1'b1, 2'b01);
        prog_stn(STN);

        // R7: abort after three bytes, then a full frame
        wr(2'd3, 16'h0020);
        for (int k = 0; k < 3; k++) begin
            cyc(1'b1, k == 0, BCAST[8*k +: 8]);
            check("R7 no decision on partial", 8'(dec_valid), 8'h0);
        end
        send(STN, 1'b0, "R7");
        expect_dec("R7 restart", 1'b1, 2'b01);
        // R7: restart five bytes in, six bytes counted from the new start
        for (int k = 0; k < 5; k++) cyc(1'b1, k == 0, STN[8*k +: 8]);
        send(STN, 1'b0, "R7b");
        expect_dec("R7 late restart", 1'b1, 2'b01);

        // R8: mid-frame rewrite of station and control
        cyc(1'b1, 1'b1, STN[7:0]);
        cyc(1'b1, 1'b0, STN[15:8]);
        wr(2'd0, 16'h1234);
        wr(2'd3, 16'h0000);
        for (int k = 2; k < 6; k++) begin
            cyc(1'b1, 1'b0, STN[8*k +: 8]);
            if (k < 5) check("R8 no early", 8'(dec_valid), 8'h0);
        end
        expect_dec("R8 old settings kept", 1'b1, 2'b01);
        wr(2'd3, 16'h0020);
        send(STN, 1'b0, "R8");
        expect_dec("R8 new station next frame", 1'b0, 2'b00);
        send(48'h1234_4D3C_1A02, 1'b0, "R8");
        expect_dec("R8 new station matches", 1'b1, 2'b01);
        prog_stn(STN);

        // R9: stray bytes outside a frame and after the sixth
        for (int k = 0; k < 8; k++) begin
            cyc(1'b1, 1'b0, STN[8*(k%6) +: 8]);
            check("R9 stray byte ignored", 8'(dec_valid), 8'h0);
        end
        send(STN, 1'b0, "R9");
        expect_dec("R9 frame", 1'b1, 2'b01);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b1, 1'b0, 8'hFF);
            check("R9 trailing byte ignored", 8'(dec_valid), 8'h0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule